// File: doc/BRIEF.md
# Latched Seven-Segment Decoder with Cascadable Zero Blanking

This block sits behind a four-decade BCD counter and turns its digits into seven-segment drive bits. A digit register captures the four BCD digits and the half-digit (overflow) flag on every clock edge at which the active-low store input is asserted. While store is deasserted the register keeps its contents, so the display shows a frozen reading while the counter keeps running.

The decode runs from the held state. Leading zeros are suppressed when the blanking-enable input is high and the half-digit is clear. The blanking-chain output reports that every digit of this block is blank. It is wired to the blanking-enable input of the next lower-order block, so a chain of four-digit blocks blanks leading zeros across the whole number. The path from blanking input to blanking output and segments is combinational, so a whole chain settles in the same cycle.

Top module: `seg_latch_decoder`

## Requirements
- R1: After reset, and until the first store, the held digits are all zero and the half-digit flag is clear. With `lzb_i` high, all 28 digit segments and `half_seg_o` are 0 and `lzb_o` is 1.
- R2: When `store_ni` is 0 at a rising clock edge, `digits_i` and `half_i` are captured at that edge. The outputs show the captured values right after that edge.
- R3: When `store_ni` is 1 at a rising clock edge, the held digits and flag do not change, whatever `digits_i` and `half_i` do.
- R4: Digit k, with k = 0 the least significant, is read from `digits_i[4k+3:4k]` and drives `seg_o[7k+6:7k]`. Bit 0 is segment a and bit 6 is segment g. Codes 0 to 9 give the patterns 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R5: BCD codes 10 to 15 drive all seven segments of that digit off. Such a digit is not counted as zero for blanking.
- R6: When `lzb_i` is 1 and the held half-digit is clear, a digit is blanked (all segments off) if it is zero and every more significant digit is also blanked. The most significant digit is blanked when it is zero.
- R7: When `lzb_i` is 0, no digit is blanked and every held zero shows as 0x3F.
- R8: When the held half-digit flag is set, `half_seg_o` is 1, no digit is blanked, and zeros show as 0x3F.
- R9: `lzb_o` is 1 exactly when all four digits are blanked. It is therefore always 0 when `lzb_i` is 0 or the half-digit flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| store_ni | input | 1 | Load held digits on this edge when low |
| digits_i | input | 16 | Four BCD digits, digit 0 in bits 3:0 |
| half_i | input | 1 | Half-digit / overflow flag from the counter |
| lzb_i | input | 1 | Blanking enable from the higher-order block |
| seg_o | output | 28 | Segment bits, 7 per digit, a in the low bit |
| half_seg_o | output | 1 | Half-digit segment |
| lzb_o | output | 1 | All digits of this block are blanked |

## Verification
Captured digits reach the outputs right after the rising edge at which `store_ni` was sampled low. The bench drives inputs on the falling edge and compares one time unit after the following rising edge, against a model that holds its own copy of the held state. `lzb_i` acts combinationally on the held state, so a change of it is checked in the same half cycle before the next edge. An exhaustive sweep of all 65536 digit patterns with blanking enabled is followed by strided sweeps with blanking disabled and with the half-digit set, and by hold phases in which the inputs change under a deasserted store.

// File: rtl/seg_latch_pkg.sv
package seg_latch_pkg;
  localparam int unsigned BCD_W = 4;
  localparam int unsigned SEG_W = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // bit 0 = a ... bit 6 = g
  function automatic seg_t bcd_to_seg(input bcd_t d);
    case (d)
      4'd0: bcd_to_seg = 7'h3F;
      4'd1: bcd_to_seg = 7'h06;
      4'd2: bcd_to_seg = 7'h5B;
      4'd3: bcd_to_seg = 7'h4F;
      4'd4: bcd_to_seg = 7'h66;
      4'd5: bcd_to_seg = 7'h6D;
      4'd6: bcd_to_seg = 7'h7D;
      4'd7: bcd_to_seg = 7'h07;
      4'd8: bcd_to_seg = 7'h7F;
      4'd9: bcd_to_seg = 7'h6F;
      default: bcd_to_seg = '0;
    endcase
  endfunction
endpackage

// File: rtl/digit_hold.sv
module digit_hold #(
  parameter int unsigned WIDTH = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (!load_ni) q_o <= d_i;
  end
endmodule

// File: rtl/zero_blank_chain.sv
module zero_blank_chain #(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS-1:0] is_zero_i,
  input  logic                  enable_i,
  output logic [NUM_DIGITS-1:0] blank_o,
  output logic                  all_blank_o
);
  // ripple from the most significant digit downwards
  always_comb begin
    blank_o[NUM_DIGITS-1] = enable_i & is_zero_i[NUM_DIGITS-1];
    for (int k = NUM_DIGITS - 2; k >= 0; k--) begin
      blank_o[k] = blank_o[k+1] & is_zero_i[k];
    end
  end

  assign all_blank_o = blank_o[0];
endmodule

// File: rtl/digit_seg_decode.sv
module digit_seg_decode
  import seg_latch_pkg::*;
(
  input  bcd_t bcd_i,
  input  logic blank_i,
  output seg_t seg_o,
  output logic is_zero_o
);
  assign is_zero_o = (bcd_i == '0);
  assign seg_o     = blank_i ? '0 : bcd_to_seg(bcd_i);
endmodule

// File: rtl/seg_latch_decoder.sv
module seg_latch_decoder
  import seg_latch_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned DIG_W = NUM_DIGITS * BCD_W,
  localparam int unsigned OUT_W = NUM_DIGITS * SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_ni,
  input  logic [DIG_W-1:0] digits_i,
  input  logic             half_i,
  input  logic             lzb_i,
  output logic [OUT_W-1:0] seg_o,
  output logic             half_seg_o,
  output logic             lzb_o
);
  logic [DIG_W:0]          held_q;
  logic [DIG_W-1:0]        held_dig;
  logic                    held_half;
  logic [NUM_DIGITS-1:0]   is_zero;
  logic [NUM_DIGITS-1:0]   blank;

  digit_hold #(.WIDTH(DIG_W + 1)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_ni(store_ni),
    .d_i    ({half_i, digits_i}),
    .q_o    (held_q)
  );

  assign held_dig  = held_q[DIG_W-1:0];
  assign held_half = held_q[DIG_W];

  // a set half-digit overrides blanking
  zero_blank_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
    .is_zero_i  (is_zero),
    .enable_i   (lzb_i & ~held_half),
    .blank_o    (blank),
    .all_blank_o(lzb_o)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    digit_seg_decode u_dec (
      .bcd_i    (held_dig[k*BCD_W +: BCD_W]),
      .blank_i  (blank[k]),
      .seg_o    (seg_o[k*SEG_W +: SEG_W]),
      .is_zero_o(is_zero[k])
    );
  end

  assign half_seg_o = held_half;
endmodule

// File: rtl/seg_latch_decoder_chk.sv
module seg_latch_decoder_chk #(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned OUT_W = NUM_DIGITS * 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             store_ni,
  input logic             lzb_i,
  input logic [OUT_W-1:0] seg_o,
  input logic             half_seg_o,
  input logic             lzb_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  // R3
  hold_when_store_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && store_ni && $stable(lzb_i)) |=> ($stable(seg_o) && $stable(half_seg_o)));

  // R9
  all_blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lzb_o |-> (seg_o == '0 && !half_seg_o));

  // R8
  half_stops_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_seg_o |-> !lzb_o);

  // R7
  no_enable_no_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lzb_i |-> !lzb_o);
endmodule

bind seg_latch_decoder seg_latch_decoder_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .store_ni  (store_ni),
  .lzb_i     (lzb_i),
  .seg_o     (seg_o),
  .half_seg_o(half_seg_o),
  .lzb_o     (lzb_o)
);

// File: tb/seg_latch_decoder_bench.sv
module seg_latch_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        store_ni = 1'b1;
  logic [15:0] digits_i = '0;
  logic        half_i = 1'b0;
  logic        lzb_i = 1'b1;
  logic [27:0] seg_o;
  logic        half_seg_o;
  logic        lzb_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] m_dig = '0;
  logic        m_half = 1'b0;

  // digits lighting each segment a..g, bit n = digit n
  localparam logic [9:0] LIT [7] = '{10'b1111101101, 10'b1110011111, 10'b1111111011,
                                     10'b1101101101, 10'b0101000101, 10'b1101110001,
                                     10'b1101111100};

  always #5 clk_i = ~clk_i;

  seg_latch_decoder u_seg_latch_decoder (
    .clk_i, .rst_ni, .store_ni, .digits_i, .half_i, .lzb_i,
    .seg_o, .half_seg_o, .lzb_o
  );

  function automatic logic [29:0] model(input logic [15:0] d, input logic h, input logic lz);
    logic [27:0] s;
    logic        bl;
    s  = '0;
    bl = lz & ~h;
    for (int k = 3; k >= 0; k--) begin
      logic [3:0] v;
      v  = d[4*k +: 4];
      bl = bl & (v == 4'd0);
      for (int g = 0; g < 7; g++)
        s[7*k+g] = !bl && v < 4'd10 && LIT[g][v];
    end
    return {bl, h, s};
  endfunction

  task automatic check(input string req);
    logic [29:0] exp, act;
    exp = model(m_dig, m_half, lzb_i);
    act = {lzb_o, half_seg_o, seg_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dig=%h half=%b lzb_i=%b act=%h exp=%h", req, m_dig, m_half, lzb_i, act, exp);
    end
  endtask

  task automatic step(input logic st_n, input logic [15:0] d, input logic h, input logic lz, input string req);
    @(negedge clk_i);
    store_ni = st_n; digits_i = d; half_i = h; lzb_i = lz;
    @(posedge clk_i);
    if (!st_n) begin m_dig = d; m_half = h; end
    #1 check(req);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #12 check("R1");
    rst_ni = 1'b1;
    step(1'b1, 16'h1234, 1'b1, 1'b1, "R1");
    // R2 R4 R5 R6 R9: exhaustive with blanking enabled
    for (int i = 0; i < 65536; i++) step(1'b0, 16'(i), 1'b0, 1'b1, "R6");
    // R7: blanking disabled
    for (int i = 0; i < 65536; i += 7) step(1'b0, 16'(i), 1'b0, 1'b0, "R7");
    // R8: half-digit set
    for (int i = 0; i < 65536; i += 7) step(1'b0, 16'(i), 1'b1, 1'b1, "R8");
    // R3: hold while store high
    step(1'b0, 16'h0050, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 200; i++) step(1'b1, 16'(i * 331), i[0], 1'b1, "R3");
    step(1'b0, 16'h0000, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 50; i++) step(1'b1, 16'(i), 1'b0, 1'b1, "R3");
    // R9: lzb_i toggles on held all-zero, combinational response
    step(1'b0, 16'h0000, 1'b0, 1'b1, "R9");
    @(negedge clk_i); store_ni = 1'b1; lzb_i = 1'b0;
    #1 check("R9");
    lzb_i = 1'b1;
    #1 check("R9");
    step(1'b0, 16'h00A0, 1'b0, 1'b1, "R5");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule